// File: doc/BRIEF.md
# USB Host Pipe Register Bank

This block holds the per-pipe register state of a USB host controller. It provides twelve independent channel register sets. Each set describes one pipe through four registers: a characteristics word, a transfer-size word, an event status word and an event mask word. Software reaches every register through a simple word-addressed write port with a combinational read port. The transfer engine reaches the bank through a separate side port. On that port it rewrites a running channel's remaining packet count and posts per-channel events such as transfer done and channel halted.

The bank limits how many channels may run at once, and it admits at most eight enabled channels. A request to enable another channel while eight are running leaves that channel's enable bit clear. While a channel is enabled, software cannot change its setup or transfer size. Only the engine's halt event clears the enable bit, which frees the slot for another pipe. Each channel raises its own interrupt line when a status bit is set and the matching mask bit is also set. A single summary line is the OR of all channel lines.

The bus address is {channel[3:0], select[1:0]}. The select field picks the register: 0 is characteristics, 1 is transfer size, 2 is status and 3 is mask.

Top module: `usb_hchan_bank`

## Requirements
- R1: After reset, every register of every channel reads zero, and `ch_en`, `ch_irq` and `irq` are zero.
- R2: The characteristics register of a disabled channel stores its fields at these bit positions:
  - max packet size at [10:0]
  - endpoint at [14:11]
  - IN direction at [15]
  - transfer type at [17:16] (0 control, 1 isochronous, 2 bulk, 3 interrupt)
  - speed at [19:18] (0 high, 1 full, 2 low)
  - device address at [26:20]
  - odd frame at [27]
  - enable at [31]

  Bits [30:28] read zero.
- R3: No more than 8 channels are ever enabled. A write with bit 31 set to a disabled channel while 8 are enabled stores the other fields but leaves enable clear.
- R4: While a channel is enabled, every software write to its characteristics register is ignored, including writes with bit 31 clear.
- R5: The transfer-size register holds the byte count at [18:0] and the packet count at [28:19], and bits [31:29] read zero. Software writes take effect only while the channel is disabled.
- R6: An engine packet-count update sets the packet count of an enabled channel and leaves its byte count unchanged. It has no effect on a disabled channel.
- R7: A posted event sets the status bits given: bit 0 transfer done, bit 1 channel halted, bit 2 stall, bit 3 transaction error. A halted event clears the channel's enable bit, and that channel's slot can then be reused.
- R8: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: `ch_irq[i]` is high exactly when channel i has a status bit set whose mask bit (mask at [3:0]) is set. `irq` is the OR of all `ch_irq`.
- R10: Addresses whose channel field is 12 to 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word address {channel, select} |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| eng_pkt_we | input | 1 | Engine packet-count update strobe |
| eng_pkt_ch | input | 4 | Channel for the packet-count update |
| eng_pkt_cnt | input | 10 | New packet count |
| eng_evt_valid | input | 1 | Engine event strobe |
| eng_evt_ch | input | 4 | Channel for the event |
| eng_evt_bits | input | 4 | Event bits (done, halted, stall, error) |
| ch_en | output | 12 | Enable bit of each channel |
| ch_irq | output | 12 | Per-channel masked interrupt |
| irq | output | 1 | OR of all channel interrupts |

## Verification
The hardest case to reach from the ports is a clearing write and an event that land on the same status bit in the same cycle. A close second is an enable request that arrives when exactly eight slots are taken, followed by a halt that frees one. The bench enables all twelve channels in order so that the last four are refused. It then halts a running channel and re-requests a refused one. It also drives the bus and the engine event port in the same clock edge to reach the set-over-clear case. A sweep over all sixteen status patterns against all sixteen masks covers the interrupt logic.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

    localparam int NUM_CH_DEF     = 12;
    localparam int MAX_ACTIVE_DEF = 8;
    localparam int DATA_W         = 32;
    localparam int MPS_W          = 11;
    localparam int EP_W           = 4;
    localparam int DEV_W          = 7;
    localparam int XFER_W         = 19;
    localparam int PKT_W          = 10;
    localparam int EVT_W          = 4;

    localparam int EN_BIT         = 31;
    localparam int EVT_DONE       = 0;
    localparam int EVT_HALT       = 1;
    localparam int EVT_STALL      = 2;
    localparam int EVT_XERR       = 3;

    typedef enum logic [1:0] {
        SPD_HIGH = 2'd0,
        SPD_FULL = 2'd1,
        SPD_LOW  = 2'd2,
        SPD_RSVD = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        XT_CTRL = 2'd0,
        XT_ISO  = 2'd1,
        XT_BULK = 2'd2,
        XT_INTR = 2'd3
    } xtype_e;

    typedef enum logic [1:0] {
        RS_CHAR  = 2'd0,
        RS_TSIZE = 2'd1,
        RS_STS   = 2'd2,
        RS_MSK   = 2'd3
    } regsel_e;

    // Pipe setup, LSB first: mps, ep, dir, type, speed, device, odd frame
    typedef struct packed {
        logic             odd;
        logic [DEV_W-1:0] dev;
        speed_e           spd;
        xtype_e           xt;
        logic             dir_in;
        logic [EP_W-1:0]  ep;
        logic [MPS_W-1:0] mps;
    } chcfg_t;

    typedef struct packed {
        logic [PKT_W-1:0]  pkts;
        logic [XFER_W-1:0] bytes;
    } tsize_t;

    localparam int CFG_W = $bits(chcfg_t);
    localparam int TSZ_W = $bits(tsize_t);

    function automatic logic [DATA_W-1:0] pack_char(input logic en, input chcfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFG_W-1:0] = c;
        w[EN_BIT]    = en;
        return w;
    endfunction

    function automatic chcfg_t unpack_cfg(input logic [DATA_W-1:0] w);
        return chcfg_t'(w[CFG_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] pack_tsize(input tsize_t t);
        logic [DATA_W-1:0] w;
        w = '0;
        w[TSZ_W-1:0] = t;
        return w;
    endfunction

endpackage

// File: rtl/hcb_admit.sv
module hcb_admit #(
    parameter int NUM_CH     = 12,
    parameter int MAX_ACTIVE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] en_vec,
    output logic              slot_free
);
    localparam int CNT_W = $clog2(NUM_CH + 1);

    logic [CNT_W-1:0] active;

    always_comb begin
        active = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            active = active + CNT_W'(en_vec[i]);
        end
    end

    assign slot_free = (active < CNT_W'(MAX_ACTIVE));

    // R3: the running set never exceeds the slot limit
    a_r3_active_limit: assert property (@(posedge clk) disable iff (rst)
        $countones(en_vec) <= MAX_ACTIVE);

    // R3: with no slot free, the running set cannot grow
    a_r3_no_growth: assert property (@(posedge clk) disable iff (rst)
        !slot_free |=> ($countones(en_vec) <= $countones($past(en_vec))));

endmodule

// File: rtl/hcb_channel.sv
module hcb_channel
    import hcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_char,
    input  logic              wr_tsize,
    input  logic              wr_sts,
    input  logic              wr_msk,
    input  logic [DATA_W-1:0] wdata,
    input  logic              admit,
    input  logic              pkt_we,
    input  logic [PKT_W-1:0]  pkt_val,
    input  logic              evt_valid,
    input  logic [EVT_W-1:0]  evt_bits,
    output logic              en_q,
    output chcfg_t            cfg_q,
    output tsize_t            tsz_q,
    output logic [EVT_W-1:0]  sts_q,
    output logic [EVT_W-1:0]  msk_q,
    output logic              irq
);
    logic             halt_now;
    logic [EVT_W-1:0] clr_bits;
    logic [EVT_W-1:0] set_bits;

    assign halt_now = evt_valid & evt_bits[EVT_HALT];
    assign clr_bits = wr_sts ? wdata[EVT_W-1:0] : '0;
    assign set_bits = evt_valid ? evt_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            cfg_q <= '0;
            tsz_q <= '0;
            sts_q <= '0;
            msk_q <= '0;
        end else begin
            if (wr_char && !en_q) begin
                cfg_q <= unpack_cfg(wdata);
                en_q  <= wdata[EN_BIT] & admit;
            end else if (halt_now) begin
                en_q  <= 1'b0;
            end

            if (wr_tsize && !en_q) begin
                tsz_q <= tsize_t'(wdata[TSZ_W-1:0]);
            end else if (pkt_we && en_q) begin
                tsz_q.pkts <= pkt_val;
            end

            sts_q <= (sts_q & ~clr_bits) | set_bits;

            if (wr_msk) begin
                msk_q <= wdata[EVT_W-1:0];
            end
        end
    end

    assign irq = |(sts_q & msk_q);

    // R4: setup of a running pipe holds until the engine halts it
    a_r4_char_locked: assert property (@(posedge clk) disable iff (rst)
        (en_q && !halt_now) |=> (en_q && $stable(cfg_q)));

    // R5: byte count cannot move while enabled
    a_r5_bytes_locked: assert property (@(posedge clk) disable iff (rst)
        en_q |=> $stable(tsz_q.bytes));

    // R6: packet count of an idle channel moves only by a bus write
    a_r6_pkts_idle: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !wr_tsize) |=> $stable(tsz_q.pkts));

    // R7: halt on a running pipe releases it
    a_r7_halt_clears: assert property (@(posedge clk) disable iff (rst)
        (halt_now && en_q) |=> !en_q);

    // R8: posted event bits are present the cycle after, whatever the bus did
    a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> ((sts_q & $past(evt_bits)) == $past(evt_bits)));

endmodule

// File: rtl/usb_hchan_bank.sv
module usb_hchan_bank
    import hcb_pkg::*;
#(
    parameter int NUM_CH     = NUM_CH_DEF,
    parameter int MAX_ACTIVE = MAX_ACTIVE_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(NUM_CH)+1:0]  bus_addr,
    input  logic                       bus_wen,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       eng_pkt_we,
    input  logic [$clog2(NUM_CH)-1:0]  eng_pkt_ch,
    input  logic [PKT_W-1:0]           eng_pkt_cnt,
    input  logic                       eng_evt_valid,
    input  logic [$clog2(NUM_CH)-1:0]  eng_evt_ch,
    input  logic [EVT_W-1:0]           eng_evt_bits,
    output logic [NUM_CH-1:0]          ch_en,
    output logic [NUM_CH-1:0]          ch_irq,
    output logic                       irq
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = CH_W + 2;

    logic [CH_W-1:0] ch_sel;
    regsel_e         rsel;
    logic            addr_ok;
    logic            slot_free;

    chcfg_t           cfg_a [NUM_CH];
    tsize_t           tsz_a [NUM_CH];
    logic [EVT_W-1:0] sts_a [NUM_CH];
    logic [EVT_W-1:0] msk_a [NUM_CH];

    assign ch_sel  = bus_addr[ADDR_W-1:2];
    assign rsel    = regsel_e'(bus_addr[1:0]);
    assign addr_ok = (int'(ch_sel) < NUM_CH);

    hcb_admit #(
        .NUM_CH     (NUM_CH),
        .MAX_ACTIVE (MAX_ACTIVE)
    ) admit_i (
        .clk       (clk),
        .rst       (rst),
        .en_vec    (ch_en),
        .slot_free (slot_free)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = bus_wen && addr_ok && (ch_sel == CH_W'(i));

        hcb_channel chan_i (
            .clk       (clk),
            .rst       (rst),
            .wr_char   (hit && rsel == RS_CHAR),
            .wr_tsize  (hit && rsel == RS_TSIZE),
            .wr_sts    (hit && rsel == RS_STS),
            .wr_msk    (hit && rsel == RS_MSK),
            .wdata     (bus_wdata),
            .admit     (slot_free),
            .pkt_we    (eng_pkt_we && eng_pkt_ch == CH_W'(i)),
            .pkt_val   (eng_pkt_cnt),
            .evt_valid (eng_evt_valid && eng_evt_ch == CH_W'(i)),
            .evt_bits  (eng_evt_bits),
            .en_q      (ch_en[i]),
            .cfg_q     (cfg_a[i]),
            .tsz_q     (tsz_a[i]),
            .sts_q     (sts_a[i]),
            .msk_q     (msk_a[i]),
            .irq       (ch_irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            case (rsel)
                RS_CHAR:  bus_rdata = pack_char(ch_en[ch_sel], cfg_a[ch_sel]);
                RS_TSIZE: bus_rdata = pack_tsize(tsz_a[ch_sel]);
                RS_STS:   bus_rdata = {{(DATA_W-EVT_W){1'b0}}, sts_a[ch_sel]};
                RS_MSK:   bus_rdata = {{(DATA_W-EVT_W){1'b0}}, msk_a[ch_sel]};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = |ch_irq;

    // R10: a write outside the bank leaves every enable where it was unless halted
    a_r10_oob_no_enable: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && !addr_ok) |=> ((ch_en & ~$past(ch_en)) == '0));

endmodule

// File: tb/usb_hchan_bank_tb_top.sv
module usb_hchan_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 12;
    localparam int NMAX = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_wen;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        eng_pkt_we;
    logic [3:0]  eng_pkt_ch;
    logic [9:0]  eng_pkt_cnt;
    logic        eng_evt_valid;
    logic [3:0]  eng_evt_ch;
    logic [3:0]  eng_evt_bits;
    logic [11:0] ch_en;
    logic [11:0] ch_irq;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] m_char [NCH];
    logic [31:0] m_tsz  [NCH];
    logic [3:0]  m_sts  [NCH];
    logic [3:0]  m_msk  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_hchan_bank dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_pkt_we(eng_pkt_we), .eng_pkt_ch(eng_pkt_ch), .eng_pkt_cnt(eng_pkt_cnt),
        .eng_evt_valid(eng_evt_valid), .eng_evt_ch(eng_evt_ch), .eng_evt_bits(eng_evt_bits),
        .ch_en(ch_en), .ch_irq(ch_irq), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int active_cnt();
        int n = 0;
        for (int i = 0; i < NCH; i++) n += int'(m_char[i][31]);
        return n;
    endfunction

    function automatic logic [11:0] model_en();
        logic [11:0] v;
        for (int i = 0; i < NCH; i++) v[i] = m_char[i][31];
        return v;
    endfunction

    task automatic rd(input int ch, input int sel, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'((ch << 2) | sel);
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_raw(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 6'((ch << 2) | sel);
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(posedge clk);
        #1;
        bus_wen   = 1'b0;
    endtask

    task automatic wr_char(input int ch, input logic [31:0] d);
        logic [31:0] nc;
        if (!m_char[ch][31]) begin
            nc = d & 32'h0FFF_FFFF;
            if (d[31] && active_cnt() < NMAX) nc[31] = 1'b1;
            m_char[ch] = nc;
        end
        wr_raw(ch, 0, d);
    endtask

    task automatic wr_tsz(input int ch, input logic [31:0] d);
        if (!m_char[ch][31]) m_tsz[ch] = d & 32'h1FFF_FFFF;
        wr_raw(ch, 1, d);
    endtask

    task automatic wr_sts(input int ch, input logic [3:0] d);
        m_sts[ch] = m_sts[ch] & ~d;
        wr_raw(ch, 2, {28'd0, d});
    endtask

    task automatic wr_msk(input int ch, input logic [3:0] d);
        m_msk[ch] = d;
        wr_raw(ch, 3, {28'd0, d});
    endtask

    task automatic eng_evt(input int ch, input logic [3:0] b);
        m_sts[ch] = m_sts[ch] | b;
        if (b[1]) m_char[ch][31] = 1'b0;
        @(negedge clk);
        eng_evt_ch = 4'(ch); eng_evt_bits = b; eng_evt_valid = 1'b1;
        @(posedge clk);
        #1;
        eng_evt_valid = 1'b0;
    endtask

    task automatic eng_pkt(input int ch, input logic [9:0] v);
        if (m_char[ch][31]) m_tsz[ch][28:19] = v;
        @(negedge clk);
        eng_pkt_ch = 4'(ch); eng_pkt_cnt = v; eng_pkt_we = 1'b1;
        @(posedge clk);
        #1;
        eng_pkt_we = 1'b0;
    endtask

    task automatic dump_check(input string req);
        logic [31:0] d;
        for (int c = 0; c < NCH; c++) begin
            rd(c, 0, d); chk(req, $sformatf("char ch%0d", c), d, m_char[c]);
            rd(c, 1, d); chk(req, $sformatf("tsize ch%0d", c), d, m_tsz[c]);
            rd(c, 2, d); chk(req, $sformatf("sts ch%0d", c), d, {28'd0, m_sts[c]});
            rd(c, 3, d); chk(req, $sformatf("msk ch%0d", c), d, {28'd0, m_msk[c]});
        end
        chk(req, "ch_en", {20'd0, ch_en}, {20'd0, model_en()});
    endtask

    function automatic logic [31:0] cfg_word(input int i);
        int mps = 64 * i + 8;
        int ep  = (i + 1) % 16;
        int dir = (i >> 1) & 1;
        int xt  = i % 4;
        int spd = i % 3;
        int dev = (i * 9 + 3) % 128;
        int odd = i & 1;
        return 32'(mps | (ep << 11) | (dir << 15) | (xt << 16) | (spd << 18) | (dev << 20) | (odd << 27));
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bus_addr = '0; bus_wen = 0; bus_wdata = '0;
        eng_pkt_we = 0; eng_pkt_ch = '0; eng_pkt_cnt = '0;
        eng_evt_valid = 0; eng_evt_ch = '0; eng_evt_bits = '0;
        for (int i = 0; i < NCH; i++) begin
            m_char[i] = '0; m_tsz[i] = '0; m_sts[i] = '0; m_msk[i] = '0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        dump_check("R1");
        chk("R1", "ch_irq", {20'd0, ch_irq}, 32'd0);
        chk("R1", "irq", {31'd0, irq}, 32'd0);

        // R2 and R5: setup stored while disabled; reserved bits set in the write read back zero
        for (int i = 0; i < NCH; i++) begin
            wr_char(i, cfg_word(i) | 32'h7000_0000);
            rd(i, 0, d); chk("R2", $sformatf("char ch%0d", i), d, cfg_word(i));
            wr_tsz(i, 32'hE000_0000 | (32'(i + 2) << 19) | 32'(1000 * i + 7));
            rd(i, 1, d); chk("R5", $sformatf("tsize ch%0d", i), d, m_tsz[i]);
        end

        // R3: enable all in order, only eight are admitted
        for (int i = 0; i < NCH; i++) begin
            wr_char(i, cfg_word(i) | 32'h8000_0000);
            rd(i, 0, d);
            chk("R3", $sformatf("enable request ch%0d", i), d,
                cfg_word(i) | ((i < NMAX) ? 32'h8000_0000 : 32'h0));
            chk("R3", "ch_en", {20'd0, ch_en}, {20'd0, model_en()});
        end

        // R4: writes to a running channel are ignored
        wr_char(0, 32'h0000_1234);
        rd(0, 0, d); chk("R4", "char ch0 locked", d, cfg_word(0) | 32'h8000_0000);
        // R5: transfer size locked while enabled
        wr_tsz(0, 32'h0ABC_DEF0);
        rd(0, 1, d); chk("R5", "tsize ch0 locked", d, m_tsz[0]);

        // R6: engine packet update on enabled vs disabled channel
        eng_pkt(1, 10'h2A5);
        rd(1, 1, d); chk("R6", "pkts ch1 updated", d, (32'h2A5 << 19) | 32'(1007));
        eng_pkt(9, 10'h155);
        rd(9, 1, d); chk("R6", "pkts ch9 ignored", d, m_tsz[9]);

        // R7: halt frees a slot, then a refused channel is admitted
        eng_evt(2, 4'b0010);
        rd(2, 2, d); chk("R7", "halt status ch2", d, 32'h2);
        chk("R7", "ch2 enable cleared", {31'd0, ch_en[2]}, 32'd0);
        wr_char(9, cfg_word(9) | 32'h8000_0000);
        chk("R7", "ch9 admitted after halt", {31'd0, ch_en[9]}, 32'd1);
        wr_char(10, cfg_word(10) | 32'h8000_0000);
        chk("R3", "ch10 still refused", {31'd0, ch_en[10]}, 32'd0);

        // R8: write-one-to-clear sweep on ch11 (idle)
        for (int v = 0; v < 16; v++) begin
            eng_evt(11, 4'hD);
            wr_sts(11, 4'(v));
            rd(11, 2, d); chk("R8", $sformatf("w1c %0d", v), d, {28'd0, m_sts[11]});
        end
        // R8: event beats same-cycle clear
        wr_sts(11, 4'hF);
        m_sts[11] = 4'b0100;
        @(negedge clk);
        bus_addr = 6'((11 << 2) | 2); bus_wdata = 32'hF; bus_wen = 1;
        eng_evt_ch = 4'd11; eng_evt_bits = 4'b0100; eng_evt_valid = 1;
        @(posedge clk);
        #1 bus_wen = 0; eng_evt_valid = 0;
        rd(11, 2, d); chk("R8", "set wins over clear", d, 32'h4);
        wr_sts(11, 4'hF);

        // R9: every status pattern against every mask on ch3
        for (int s = 0; s < 16; s++) begin
            wr_sts(3, 4'hF);
            if (s != 0) eng_evt(3, 4'(s));
            for (int m = 0; m < 16; m++) begin
                wr_msk(3, 4'(m));
                #1;
                chk("R9", $sformatf("ch_irq3 s%0d m%0d", s, m), {31'd0, ch_irq[3]}, {31'd0, |(4'(s) & 4'(m))});
                chk("R9", $sformatf("irq s%0d m%0d", s, m), {31'd0, irq}, {31'd0, |(4'(s) & 4'(m))});
            end
        end
        wr_msk(3, 4'h0);
        dump_check("R9");

        // R10: out-of-range channel fields
        for (int c = NCH; c < 16; c++) begin
            for (int s = 0; s < 4; s++) begin
                wr_raw(c, s, 32'hFFFF_FFFF);
                rd(c, s, d); chk("R10", $sformatf("oob ch%0d sel%0d", c, s), d, 32'd0);
            end
        end
        dump_check("R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule